// File: doc/BRIEF.md
# Precharge Spacing Timing Gate

This block sits between a memory controller's command scheduler and a DRAM device whose banks are grouped into one or more bank sets. It holds each precharge-type request until the device's minimum spacing rules are met, and then lets it through. Two spacing rules apply. The first sets the minimum gap between precharges that land in the same bank set. The second sets the minimum gap between precharges to different bank sets. Both gaps are given in clock cycles and come from configuration inputs that can change at run time.

A request names a primary bank set. It may also be a paired packet that carries a second, independent precharge, such as a refresh-precharge next to an ordinary one, aimed at a second bank set. The request is accepted on a valid/ready handshake. In the cycle it is accepted, the block raises a one-cycle issue pulse and a mask of the bank sets served. A paired packet issues both commands on the same edge, and only when the cross-set gap is zero. A paired packet whose two commands name the same bank set is consumed with an error flag and issues nothing.

Top module: `pc_spacing_gate`

## Requirements
- R1: After reset every spacing counter is saturated, so with no earlier precharge, ready is high and the first request issues in the cycle it is presented.
- R2: Two issues that include the same bank set are at least `cfg_same_gap` cycles apart (issue cycles N and M with M - N >= cfg_same_gap), and ready stays low while that gap is not yet met.
- R3: Any issue comes at least `cfg_diff_gap` cycles after the previous issue to any bank set.
- R4: With `cfg_diff_gap` equal to `cfg_same_gap`, a request to a different bank set waits the full same-set gap after the last issue.
- R5: With `cfg_diff_gap` below `cfg_same_gap`, a precharge to one bank set can be placed between two precharges to another bank set, for example one cycle after the first when the cross-set gap is 1.
- R6: A paired request (`req_dual`=1) to two different bank sets with `cfg_diff_gap`=0 issues both commands in one cycle once both sets meet the same-set gap; `issue_mask` then has both bits set.
- R7: A paired request to two different bank sets keeps ready low and does not issue while `cfg_diff_gap` is not 0.
- R8: A paired request whose two set fields are equal is accepted with ready high, pulses `err_same_set`, issues nothing, and leaves every spacing counter unchanged.
- R9: `issue_pulse` is high only in a cycle where `req_valid` and `req_ready` are both high, and `issue_mask` bit s is 1 exactly when bank set s is served in that cycle, and is all zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_same_gap | input | CNT_W | Minimum cycles between precharges to one bank set |
| cfg_diff_gap | input | CNT_W | Minimum cycles between precharges to different bank sets |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request may be accepted this cycle |
| req_dual | input | 1 | Request carries a second precharge command |
| req_set_a | input | SET_W | Bank set of the primary command |
| req_set_b | input | SET_W | Bank set of the second command (paired requests only) |
| issue_pulse | output | 1 | Precharge issued this cycle |
| issue_mask | output | NUM_SETS | Bank sets served this cycle, bit s for set s |
| err_same_set | output | 1 | Paired request named one bank set twice and was dropped |

## Verification
Two sets can be served on one edge. Separately, a cross-set request can fall inside a same-set window that is still open. Both are provoked by changing the cross-set gap between sequences. With the gap at 0, paired packets must issue both sets in the cycle they are accepted. With gaps of 1 and 2, an interleaved request to the other set must land ahead of the pending same-set repeat. A scoreboard predicts the issue cycle and the served mask of each request from its own record of earlier issues, and compares both against what the design reports.

// File: rtl/pc_gate_pkg.sv
package pc_gate_pkg;

  // True when enough cycles have elapsed to satisfy a spacing gap.
  function automatic logic gap_met(input int unsigned elapsed,
                                   input int unsigned gap);
    return elapsed >= gap;
  endfunction

  // Next value of a saturating elapsed-cycle counter.
  function automatic int unsigned elapsed_step(input int unsigned cur,
                                               input int unsigned top,
                                               input logic        restart);
    if (restart)
      return 1;
    else if (cur >= top)
      return top;
    else
      return cur + 1;
  endfunction

endpackage

// File: rtl/pc_set_timer.sv
module pc_set_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  output logic [CNT_W-1:0] elapsed
);
  import pc_gate_pkg::*;

  localparam int unsigned TOP = (1 << CNT_W) - 1;

  logic [CNT_W-1:0] elapsed_nx;

  always_comb elapsed_nx = CNT_W'(elapsed_step(32'(elapsed), TOP, restart));

  always_ff @(posedge clk) begin
    if (!rst_n) elapsed <= '1;
    else        elapsed <= elapsed_nx;
  end

  // An issue restarts the window at one elapsed cycle.
  assert_restart_after_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> elapsed == CNT_W'(1));

  // Without an issue the window never shrinks.
  assert_window_monotone_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> elapsed >= $past(elapsed));

endmodule

// File: rtl/pc_issue_gate.sv
module pc_issue_gate #(
  parameter int NUM_SETS = 2,
  parameter int SET_W    = 1,
  parameter int CNT_W    = 3
) (
  input  logic                             req_valid,
  input  logic                             req_dual,
  input  logic [SET_W-1:0]                 req_set_a,
  input  logic [SET_W-1:0]                 req_set_b,
  input  logic [NUM_SETS-1:0][CNT_W-1:0]   set_elapsed,
  input  logic [CNT_W-1:0]                 any_elapsed,
  input  logic [CNT_W-1:0]                 same_gap,
  input  logic [CNT_W-1:0]                 diff_gap,
  output logic                             req_ready,
  output logic                             fire,
  output logic [NUM_SETS-1:0]              fire_mask,
  output logic                             err
);
  import pc_gate_pkg::*;

  logic [CNT_W-1:0] elapsed_a, elapsed_b;
  logic             same_target;
  logic             a_ok, b_ok, pair_ok;

  // Select the window of each named bank set without an out-of-range index.
  always_comb begin
    elapsed_a = '0;
    elapsed_b = '0;
    for (int s = 0; s < NUM_SETS; s++) begin
      if (req_set_a == SET_W'(s)) elapsed_a = set_elapsed[s];
      if (req_set_b == SET_W'(s)) elapsed_b = set_elapsed[s];
    end
  end

  always_comb begin
    same_target = req_dual && (req_set_a == req_set_b);
    a_ok        = gap_met(32'(elapsed_a), 32'(same_gap)) &&
                  gap_met(32'(any_elapsed), 32'(diff_gap));
    b_ok        = gap_met(32'(elapsed_b), 32'(same_gap));
    pair_ok     = a_ok && b_ok && (diff_gap == '0);
    if (same_target)   req_ready = 1'b1;
    else if (req_dual) req_ready = pair_ok;
    else               req_ready = a_ok;
    err  = req_valid && same_target;
    fire = req_valid && req_ready && !same_target;
  end

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_mask
    assign fire_mask[s] = fire && ((req_set_a == SET_W'(s)) ||
                                   (req_dual && req_set_b == SET_W'(s)));
  end

  // A dropped paired packet never reaches the device.
  always_comb assert_err_blocks_issue_R8: assert (!(err && fire));

endmodule

// File: rtl/pc_spacing_gate.sv
module pc_spacing_gate #(
  parameter int NUM_SETS = 2,
  parameter int CNT_W    = 3,
  localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CNT_W-1:0]    cfg_same_gap,
  input  logic [CNT_W-1:0]    cfg_diff_gap,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_dual,
  input  logic [SET_W-1:0]    req_set_a,
  input  logic [SET_W-1:0]    req_set_b,
  output logic                issue_pulse,
  output logic [NUM_SETS-1:0] issue_mask,
  output logic                err_same_set
);

  logic [NUM_SETS-1:0][CNT_W-1:0] set_elapsed;
  logic [CNT_W-1:0]               any_elapsed;
  logic                           fire;
  logic [NUM_SETS-1:0]            fire_mask;

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    pc_set_timer #(.CNT_W(CNT_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (fire_mask[s]),
      .elapsed (set_elapsed[s])
    );

    // Same-set spacing holds at every issue touching set s.
    assert_same_set_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fire_mask[s] |-> set_elapsed[s] >= cfg_same_gap);
  end

  pc_set_timer #(.CNT_W(CNT_W)) u_any_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (fire),
    .elapsed (any_elapsed)
  );

  pc_issue_gate #(
    .NUM_SETS (NUM_SETS),
    .SET_W    (SET_W),
    .CNT_W    (CNT_W)
  ) u_gate (
    .req_valid   (req_valid),
    .req_dual    (req_dual),
    .req_set_a   (req_set_a),
    .req_set_b   (req_set_b),
    .set_elapsed (set_elapsed),
    .any_elapsed (any_elapsed),
    .same_gap    (cfg_same_gap),
    .diff_gap    (cfg_diff_gap),
    .req_ready   (req_ready),
    .fire        (fire),
    .fire_mask   (fire_mask),
    .err         (err_same_set)
  );

  assign issue_pulse = fire;
  assign issue_mask  = fire_mask;

  assert_diff_set_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    issue_pulse |-> any_elapsed >= cfg_diff_gap);

  assert_pair_needs_zero_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(issue_mask) > 1) |-> (cfg_diff_gap == '0) && req_dual);

  assert_issue_on_handshake_R9: assert property (@(posedge clk) disable iff (!rst_n)
    issue_pulse |-> req_valid && req_ready && (issue_mask != '0));

  assert_mask_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_pulse |-> issue_mask == '0);

  assert_counters_held_on_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_same_set |=> any_elapsed >= $past(any_elapsed));

endmodule

// File: tb/pc_spacing_gate_test.sv
module pc_spacing_gate_test;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_SETS   = 2;
  localparam int CNT_W      = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [CNT_W-1:0] cfg_same_gap = 3'd4;
  logic [CNT_W-1:0] cfg_diff_gap = 3'd4;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic             req_dual = 1'b0;
  logic [0:0]       req_set_a = '0;
  logic [0:0]       req_set_b = '0;
  logic             issue_pulse;
  logic [1:0]       issue_mask;
  logic             err_same_set;

  int tests = 0, fails = 0, cyc = 0;
  int last_set [NUM_SETS];
  int last_any;
  int exp_cyc_q [$];
  int exp_mask_q [$];
  string exp_tag_q [$];

  pc_spacing_gate #(.NUM_SETS(NUM_SETS), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_same_gap(cfg_same_gap), .cfg_diff_gap(cfg_diff_gap),
    .req_valid(req_valid), .req_ready(req_ready), .req_dual(req_dual),
    .req_set_a(req_set_a), .req_set_b(req_set_b), .issue_pulse(issue_pulse),
    .issue_mask(issue_mask), .err_same_set(err_same_set)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Monitor: pops predicted issues and compares cycle and mask.
  always @(negedge clk) begin
    if (rst_n && issue_pulse) begin
      if (exp_cyc_q.size() == 0) begin
        check(1'b0, "R9 unexpected issue", int'(issue_mask), 0);
      end else begin
        int ec, em;
        string t;
        ec = exp_cyc_q.pop_front();
        em = exp_mask_q.pop_front();
        t  = exp_tag_q.pop_front();
        check(cyc == ec, {t, " issue cycle"}, cyc, ec);
        check(int'(issue_mask) == em, {"R9 ", t, " mask"}, int'(issue_mask), em);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Driver: predicts the issue, pushes it, then holds the request until accepted.
  task automatic send(input bit dual, input int a, input int b, input string tag);
    int e;
    int m;
    e = max2(cyc, max2(last_set[a] + int'(cfg_same_gap), last_any + int'(cfg_diff_gap)));
    m = 1 << a;
    if (dual) begin
      e = max2(e, last_set[b] + int'(cfg_same_gap));
      m = m | (1 << b);
    end
    exp_cyc_q.push_back(e);
    exp_mask_q.push_back(m);
    exp_tag_q.push_back(tag);
    last_set[a] = e;
    if (dual) last_set[b] = e;
    last_any = e;
    req_valid = 1'b1;
    req_dual  = dual;
    req_set_a = 1'(a);
    req_set_b = 1'(b);
    forever begin
      @(negedge clk);
      if (req_ready) break;
      @(posedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    req_dual  = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    check(1'b0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int s = 0; s < NUM_SETS; s++) last_set[s] = -100;
    last_any = -100;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    check(issue_pulse == 1'b0, "R1 no issue after reset", int'(issue_pulse), 0);
    check(err_same_set == 1'b0, "R1 no error after reset", int'(err_same_set), 0);
    @(posedge clk);
    #1;

    // R1, R2, R4: equal gaps
    send(0, 0, 0, "R1 first");
    send(0, 0, 0, "R2 same set");
    send(0, 1, 0, "R4 other set full gap");
    idle(8);

    // R3, R5: cross-set gap 2
    cfg_diff_gap = 3'd2;
    send(0, 0, 0, "R3 start");
    send(0, 1, 0, "R3 cross gap 2");
    send(0, 0, 0, "R5 set0 after interleave");
    idle(8);

    // R5: cross-set gap 1
    cfg_diff_gap = 3'd1;
    send(0, 0, 0, "R5 start");
    send(0, 1, 0, "R5 one cycle later");
    send(0, 0, 0, "R5 set0 repeat");
    idle(8);

    // R6: paired issue at zero cross-set gap
    cfg_diff_gap = 3'd0;
    send(1, 0, 1, "R6 pair");
    send(1, 1, 0, "R6 pair again");
    send(0, 0, 0, "R2 after pair");
    idle(8);

    // R7: paired request stalls for non-zero cross-set gap
    cfg_diff_gap = 3'd2;
    req_valid = 1'b1;
    req_dual  = 1'b1;
    req_set_a = 1'b0;
    req_set_b = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(req_ready == 1'b0, "R7 pair ready", int'(req_ready), 0);
      check(issue_pulse == 1'b0, "R7 pair no issue", int'(issue_pulse), 0);
      @(posedge clk);
      #1;
    end
    req_valid = 1'b0;
    req_dual  = 1'b0;
    idle(8);

    // R8: same-set pair is dropped with an error
    req_valid = 1'b1;
    req_dual  = 1'b1;
    req_set_a = 1'b1;
    req_set_b = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R8 ready on bad pair", int'(req_ready), 1);
    check(err_same_set == 1'b1, "R8 error flag", int'(err_same_set), 1);
    check(issue_pulse == 1'b0, "R8 no issue", int'(issue_pulse), 0);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    req_dual  = 1'b0;
    @(negedge clk);
    check(err_same_set == 1'b0, "R8 error is one cycle", int'(err_same_set), 0);
    @(posedge clk);
    #1;
    send(0, 1, 0, "R8 counters untouched");
    idle(4);

    check(exp_cyc_q.size() == 0, "R9 all issues seen", exp_cyc_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule